// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move data into and out of a byte-wide packet memory through one data port. Software first loads a starting address and a byte count. After that, every strobe on the port performs one access at the current address. The engine then moves the address forward by the access length and takes the same amount off the count. Each strobe is an 8-bit, 16-bit or 32-bit access. A narrow strobe is 8 or 16 bits, as a word-mode input selects. A wide strobe is always 32 bits.

The address runs inside a receive ring. When the advanced address lands exactly on the ring stop address, it is reloaded with the ring start address. A small 32-byte identity area sits at the bottom of the address space. Reset fills it from a station-address input. Packet memory is reached through an external RAM port with asynchronous read.

An access is checked against two windows: the identity area and the packet window. An access outside both returns all-ones on a read and leaves memory untouched on a write. The engine completes a multi-byte access one byte lane per cycle and shows a busy flag while it does so. A single-cycle pulse reports that the count has run out.

Top module: `rdma_port`

## Requirements
- R1: The access length is 4 bytes when `hostWide` is 1. When `hostWide` is 0, the length is 2 bytes with `wordMode` = 1 and 1 byte with `wordMode` = 0. After each accepted access that is not dropped, `curAddr` becomes the previous address plus the length.
- R2: If the address plus the length equals `ringStop`, `curAddr` becomes `ringStart` instead.
- R3: If `remCnt` is less than or equal to the length, `remCnt` becomes 0 and `dmaDone` pulses for one cycle. Otherwise `remCnt` drops by the length and `dmaDone` stays low. `dmaDone` is never high while `remCnt` is nonzero.
- R4: A write accepted while `remCnt` is 0 is dropped entirely. No memory byte changes, `curAddr` and `remCnt` keep their values, and `dmaDone` stays low. A read while `remCnt` is 0 still returns data, advances `curAddr` and pulses `dmaDone`.
- R5: For 2-byte and 4-byte accesses, bit 0 of the address is taken as 0 when forming the memory address. The advance in R1 uses the unaligned address.
- R6: An access is valid if all of its bytes lie below address 32 (identity area) or all lie in [`PMEM_START`, `MEM_END`). An invalid read returns all-ones in its lanes: 0xFF, 0xFFFF or 0xFFFFFFFF. An invalid write changes no memory byte. `curAddr` and `remCnt` still update as in R1 to R3. The RAM port is used only for valid packet-window accesses.
- R7: Byte lane i of an access, meaning data bits 8i+7..8i, maps to memory address (aligned address + i). The data is little-endian. Unused read lanes return 0.
- R8: After reset, identity byte 2k and identity byte 2k+1 both hold the value for k:
  - `macAddr` bits 8k+7..8k for k from 0 to 5;
  - 0x00 for k from 6 to 13;
  - 0x57 for k of 14 and 15.
  Writes to the identity area update it.
- R9: A strobe (`hostRd` or `hostWr`, with read winning if both are high) is accepted on a clock edge where `busy` is low. `busy` is then high for exactly as many cycles as the access length. Strobes seen while `busy` is high are ignored. `rdValid` pulses together with the result on the edge that ends `busy`.
- R10: After reset, `curAddr`, `remCnt`, `busy`, `rdValid` and `dmaDone` are 0. `setAddr` and `setCnt` load `curAddr` and `remCnt` on the next edge, and are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostRd | input | 1 | Read strobe on the data port |
| hostWr | input | 1 | Write strobe on the data port |
| hostWide | input | 1 | 1 selects a 32-bit access, 0 a narrow access |
| wordMode | input | 1 | Narrow accesses are 16-bit when 1, 8-bit when 0 |
| hostWdata | input | 32 | Write data, lane 0 in bits 7..0 |
| hostRdata | output | 32 | Read result of the last read |
| rdValid | output | 1 | One-cycle pulse when a read result is ready |
| busy | output | 1 | Access in progress, strobes held off |
| setAddr | input | 1 | Load the current address |
| setAddrVal | input | ADDR_W | Address value to load |
| setCnt | input | 1 | Load the remaining count |
| setCntVal | input | CNT_W | Count value to load |
| ringStart | input | ADDR_W | Address reloaded on wrap |
| ringStop | input | ADDR_W | Address at which the wrap happens |
| macAddr | input | 48 | Station address seeded into the identity area at reset |
| curAddr | output | ADDR_W | Current transfer address |
| remCnt | output | CNT_W | Remaining byte count |
| dmaDone | output | 1 | One-cycle pulse when the count runs out |
| ramAddr | output | ADDR_W | Packet RAM byte address |
| ramWe | output | 1 | Packet RAM write enable |
| ramRe | output | 1 | Packet RAM read enable |
| ramWdata | output | 8 | Packet RAM write byte |
| ramRdata | input | 8 | Packet RAM read byte, valid in the same cycle |

## Verification
The bench builds the engine with an 8-bit address and an 8-bit count, and places the packet window at 64 up to 128. With these values, short addresses reach every edge of the window check: the end of the identity area at 32, the gap below 64, and a wide access crossing the top of memory. The bench places the ring between 80 and 100, so a 32-bit access ending on the stop address shows the wrap. The small count lets the bench drive the count to exactly zero and then probe the dropped-write and still-reading behaviour.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       accept;  // host strobe taken this cycle
    logic       laneEn;  // one byte lane is being moved
    logic [1:0] lane;    // which lane
    logic       commit;  // last lane: update address and count
  } rdmaStrobe_t;

  function automatic logic [2:0] accessLen(input logic wide, input logic wordMode);
    return wide ? 3'd4 : (wordMode ? 3'd2 : 3'd1);
  endfunction

  // Identity area seed: each station byte repeated twice, marker at the top.
  function automatic logic [7:0] promSeed(input logic [47:0] mac, input int idx);
    int k;
    k = idx / 2;
    if (k < 6)        return mac[k*8 +: 8];
    else if (k >= 14) return 8'h57;
    else              return 8'h00;
  endfunction

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic        hostWide,
  input  logic        wordMode,
  output logic        busy,
  output rdmaStrobe_t strb
);

  logic       busyQ;
  logic [1:0] laneQ;
  logic [2:0] lenQ;
  logic       lastLane;

  assign lastLane = ({1'b0, laneQ} == (lenQ - 3'd1));

  always_comb begin
    strb.accept = (hostRd | hostWr) & ~busyQ;
    strb.laneEn = busyQ;
    strb.lane   = laneQ;
    strb.commit = busyQ & lastLane;
  end

  assign busy = busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      laneQ <= '0;
      lenQ  <= 3'd1;
    end else if (strb.accept) begin
      busyQ <= 1'b1;
      laneQ <= '0;
      lenQ  <= accessLen(hostWide, wordMode);
    end else if (busyQ) begin
      if (lastLane) busyQ <= 1'b0;
      else          laneQ <= laneQ + 2'd1;
    end
  end

endmodule

// File: rtl/rdma_dpath.sv
module rdma_dpath
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PMEM_START = 16384,
  parameter int MEM_END    = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdmaStrobe_t       strb,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostWide,
  input  logic              wordMode,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              rdValid,
  input  logic              setAddr,
  input  logic [ADDR_W-1:0] setAddrVal,
  input  logic              setCnt,
  input  logic [CNT_W-1:0]  setCntVal,
  input  logic [ADDR_W-1:0] ringStart,
  input  logic [ADDR_W-1:0] ringStop,
  input  logic [47:0]       macAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  remCnt,
  output logic              dmaDone,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  localparam int PROM_BYTES = 32;
  localparam int PROM_AW    = $clog2(PROM_BYTES);
  localparam logic [ADDR_W:0]   PROM_END_W = (ADDR_W+1)'(PROM_BYTES);
  localparam logic [ADDR_W:0]   MEM_END_W  = (ADDR_W+1)'(MEM_END);
  localparam logic [ADDR_W-1:0] PMEM_W     = ADDR_W'(PMEM_START);

  logic [7:0]        prom [PROM_BYTES];
  logic [ADDR_W-1:0] addrQ, opEa;
  logic [CNT_W-1:0]  cntQ;
  logic [2:0]        opLen;
  logic              opWr, opOk, opProm, opDrop;
  logic [31:0]       wdQ, rdQ;
  logic              rdValidQ, doneQ;

  // Access qualification, evaluated when a strobe is taken.
  logic [2:0]        newLen;
  logic [ADDR_W-1:0] newEa;
  logic [ADDR_W:0]   newEnd;
  logic              newProm, newPmem, newWr, newDrop;

  always_comb begin
    newLen  = accessLen(hostWide, wordMode);
    newEa   = (newLen != 3'd1) ? {addrQ[ADDR_W-1:1], 1'b0} : addrQ;
    newEnd  = {1'b0, newEa} + (ADDR_W+1)'(newLen);
    newProm = newEnd <= PROM_END_W;
    newPmem = (newEa >= PMEM_W) && (newEnd <= MEM_END_W);
    newWr   = hostWr & ~hostRd;
    newDrop = newWr && (cntQ == '0);
  end

  // Per-lane byte movement.
  logic [ADDR_W-1:0] laneAddr, nextSum, nextAddr;
  logic [4:0]        laneSel;
  logic [7:0]        wrByte, rdByte;
  logic [CNT_W-1:0]  lenAsCnt;
  logic              cntLast, promWe;

  always_comb begin
    laneAddr = opEa + ADDR_W'(strb.lane);
    laneSel  = {strb.lane, 3'b000};
    wrByte   = wdQ[laneSel +: 8];
    rdByte   = !opOk ? 8'hFF : (opProm ? prom[laneAddr[PROM_AW-1:0]] : ramRdata);
    promWe   = strb.laneEn & opWr & opOk & opProm & ~opDrop;
    nextSum  = addrQ + ADDR_W'(opLen);
    nextAddr = (nextSum == ringStop) ? ringStart : nextSum;
    lenAsCnt = CNT_W'(opLen);
    cntLast  = cntQ <= lenAsCnt;
  end

  assign ramAddr   = laneAddr;
  assign ramWdata  = wrByte;
  assign ramWe     = strb.laneEn & opWr & opOk & ~opProm & ~opDrop;
  assign ramRe     = strb.laneEn & ~opWr & opOk & ~opProm;
  assign hostRdata = rdQ;
  assign rdValid   = rdValidQ;
  assign dmaDone   = doneQ;
  assign curAddr   = addrQ;
  assign remCnt    = cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      cntQ     <= '0;
      opEa     <= '0;
      opLen    <= 3'd1;
      opWr     <= 1'b0;
      opOk     <= 1'b0;
      opProm   <= 1'b0;
      opDrop   <= 1'b0;
      wdQ      <= '0;
      rdQ      <= '0;
      rdValidQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      rdValidQ <= 1'b0;
      doneQ    <= 1'b0;
      if (strb.accept) begin
        opWr   <= newWr;
        opLen  <= newLen;
        opEa   <= newEa;
        opOk   <= newProm | newPmem;
        opProm <= newProm;
        opDrop <= newDrop;
        wdQ    <= hostWdata;
        rdQ    <= '0;
      end
      if (strb.laneEn && !opWr) rdQ[laneSel +: 8] <= rdByte;
      if (strb.commit && !opDrop) begin
        addrQ    <= nextAddr;
        cntQ     <= cntLast ? '0 : (cntQ - lenAsCnt);
        doneQ    <= cntLast;
        rdValidQ <= ~opWr;
      end
      if (!strb.laneEn) begin
        if (setAddr) addrQ <= setAddrVal;
        if (setCnt)  cntQ  <= setCntVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PROM_BYTES; i++) prom[i] <= promSeed(macAddr, i);
    end else if (promWe) begin
      prom[laneAddr[PROM_AW-1:0]] <= wrByte;
    end
  end

endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PMEM_START = 16384,
  parameter int MEM_END    = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostWide,
  input  logic              wordMode,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              rdValid,
  output logic              busy,
  input  logic              setAddr,
  input  logic [ADDR_W-1:0] setAddrVal,
  input  logic              setCnt,
  input  logic [CNT_W-1:0]  setCntVal,
  input  logic [ADDR_W-1:0] ringStart,
  input  logic [ADDR_W-1:0] ringStop,
  input  logic [47:0]       macAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [CNT_W-1:0]  remCnt,
  output logic              dmaDone,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  rdmaStrobe_t strb;

  rdma_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .hostWide (hostWide),
    .wordMode (wordMode),
    .busy     (busy),
    .strb     (strb)
  );

  rdma_dpath #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PMEM_START (PMEM_START),
    .MEM_END    (MEM_END)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .hostWide   (hostWide),
    .wordMode   (wordMode),
    .hostWdata  (hostWdata),
    .hostRdata  (hostRdata),
    .rdValid    (rdValid),
    .setAddr    (setAddr),
    .setAddrVal (setAddrVal),
    .setCnt     (setCnt),
    .setCntVal  (setCntVal),
    .ringStart  (ringStart),
    .ringStop   (ringStop),
    .macAddr    (macAddr),
    .curAddr    (curAddr),
    .remCnt     (remCnt),
    .dmaDone    (dmaDone),
    .ramAddr    (ramAddr),
    .ramWe      (ramWe),
    .ramRe      (ramRe),
    .ramWdata   (ramWdata),
    .ramRdata   (ramRdata)
  );

endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PMEM_START = 16384,
  parameter int MEM_END    = 32768
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              rdValid,
  input logic              dmaDone,
  input logic [CNT_W-1:0]  remCnt,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramWe,
  input logic              ramRe
);

  localparam logic [ADDR_W:0] LO_W = (ADDR_W+1)'(PMEM_START);
  localparam logic [ADDR_W:0] HI_W = (ADDR_W+1)'(MEM_END);

  // R9: the RAM is only touched while an access is in progress
  a_r9_ram_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(ramWe || ramRe));

  // R9: a read result is announced once the access has ended
  a_r9_rdvalid_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busy);

  // R4: no RAM write while the count is exhausted
  a_r4_no_write_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> remCnt != '0);

  // R6: RAM port used only inside the packet window
  a_r6_ram_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramRe) |-> (({1'b0, ramAddr} >= LO_W) && ({1'b0, ramAddr} < HI_W)));

  // R3: completion only with an empty count
  a_r3_done_means_zero: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> remCnt == '0);

  // R3: completion is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> !dmaDone);

endmodule

bind rdma_port rdma_port_chk #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .PMEM_START (PMEM_START),
  .MEM_END    (MEM_END)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .rdValid (rdValid),
  .dmaDone (dmaDone),
  .remCnt  (remCnt),
  .ramAddr (ramAddr),
  .ramWe   (ramWe),
  .ramRe   (ramRe)
);

// File: tb/tb_rdma_port.sv
module tb_rdma_port;

  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int PMEM_START = 64;
  localparam int MEM_END = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRd = 0, hostWr = 0, hostWide = 0, wordMode = 0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic rdValid, busy, dmaDone;
  logic setAddr = 0, setCnt = 0;
  logic [ADDR_W-1:0] setAddrVal = '0;
  logic [CNT_W-1:0] setCntVal = '0;
  logic [ADDR_W-1:0] ringStart = 8'd80, ringStop = 8'd100;
  logic [47:0] macAddr = 48'hF6E5D4C3B2A1;
  logic [ADDR_W-1:0] curAddr, ramAddr;
  logic [CNT_W-1:0] remCnt;
  logic ramWe, ramRe;
  logic [7:0] ramWdata;
  logic [7:0] ramRdata;
  logic [7:0] ram [256];

  always #10 clk = ~clk;  // 50 MHz

  initial for (int i = 0; i < 256; i++) ram[i] = 8'h00;
  assign ramRdata = ram[ramAddr];
  always @(posedge clk) if (ramWe) ram[ramAddr] <= ramWdata;

  rdma_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PMEM_START(PMEM_START), .MEM_END(MEM_END)) dut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr), .hostWide(hostWide),
    .wordMode(wordMode), .hostWdata(hostWdata), .hostRdata(hostRdata), .rdValid(rdValid),
    .busy(busy), .setAddr(setAddr), .setAddrVal(setAddrVal), .setCnt(setCnt),
    .setCntVal(setCntVal), .ringStart(ringStart), .ringStop(ringStop), .macAddr(macAddr),
    .curAddr(curAddr), .remCnt(remCnt), .dmaDone(dmaDone), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramRe(ramRe), .ramWdata(ramWdata), .ramRdata(ramRdata));

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 write, 1 read, 2 load address, 3 load count
  typedef struct packed {
    logic [1:0]  op;
    logic        wide;
    logic        wm;
    logic [31:0] data;
    logic [31:0] expRd;
    logic [7:0]  expAddr;
    logic [7:0]  expCnt;
    logic        expDone;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 1'b0, 1'b0, 32'd80,        32'h0,        8'd80,  8'd0,   1'b0}, // R10 load
    '{2'd3, 1'b0, 1'b0, 32'd20,        32'h0,        8'd80,  8'd20,  1'b0}, // R10 load
    '{2'd0, 1'b0, 1'b0, 32'h11,        32'h0,        8'd81,  8'd19,  1'b0}, // R1 byte write
    '{2'd0, 1'b0, 1'b1, 32'h2233,      32'h0,        8'd83,  8'd17,  1'b0}, // R5 odd addr, 16-bit
    '{2'd0, 1'b1, 1'b0, 32'h44556677,  32'h0,        8'd87,  8'd13,  1'b0}, // R5 R7 wide write
    '{2'd2, 1'b0, 1'b0, 32'd80,        32'h0,        8'd80,  8'd13,  1'b0},
    '{2'd1, 1'b1, 1'b0, 32'h0,         32'h66772233, 8'd84,  8'd9,   1'b0}, // R7 little-endian
    '{2'd1, 1'b0, 1'b0, 32'h0,         32'h55,       8'd85,  8'd8,   1'b0}, // R1 byte read
    '{2'd1, 1'b0, 1'b1, 32'h0,         32'h4455,     8'd87,  8'd6,   1'b0}, // R5 aligned read
    '{2'd2, 1'b0, 1'b0, 32'd96,        32'h0,        8'd96,  8'd6,   1'b0},
    '{2'd0, 1'b1, 1'b0, 32'hA1B2C3D4,  32'h0,        8'd80,  8'd2,   1'b0}, // R2 wrap
    '{2'd2, 1'b0, 1'b0, 32'd96,        32'h0,        8'd96,  8'd2,   1'b0},
    '{2'd1, 1'b1, 1'b0, 32'h0,         32'hA1B2C3D4, 8'd80,  8'd0,   1'b1}, // R3 count ends
    '{2'd1, 1'b0, 1'b0, 32'h0,         32'h33,       8'd81,  8'd0,   1'b1}, // R4 read at zero
    '{2'd0, 1'b0, 1'b0, 32'hEE,        32'h0,        8'd81,  8'd0,   1'b0}, // R4 dropped write
    '{2'd1, 1'b0, 1'b0, 32'h0,         32'h22,       8'd82,  8'd0,   1'b1}, // R4 memory kept
    '{2'd3, 1'b0, 1'b0, 32'd200,       32'h0,        8'd82,  8'd200, 1'b0},
    '{2'd2, 1'b0, 1'b0, 32'd30,        32'h0,        8'd30,  8'd200, 1'b0},
    '{2'd1, 1'b1, 1'b0, 32'h0,         32'hFFFFFFFF, 8'd34,  8'd196, 1'b0}, // R6 crosses 32
    '{2'd2, 1'b0, 1'b0, 32'd28,        32'h0,        8'd28,  8'd196, 1'b0},
    '{2'd1, 1'b1, 1'b0, 32'h0,         32'h57575757, 8'd32,  8'd192, 1'b0}, // R8 marker bytes
    '{2'd2, 1'b0, 1'b0, 32'd2,         32'h0,        8'd2,   8'd192, 1'b0},
    '{2'd1, 1'b0, 1'b1, 32'h0,         32'hB2B2,     8'd4,   8'd190, 1'b0}, // R8 doubled byte
    '{2'd0, 1'b0, 1'b0, 32'h5A,        32'h0,        8'd5,   8'd189, 1'b0}, // R8 identity write
    '{2'd2, 1'b0, 1'b0, 32'd4,         32'h0,        8'd4,   8'd189, 1'b0},
    '{2'd1, 1'b0, 1'b1, 32'h0,         32'hC35A,     8'd6,   8'd187, 1'b0}, // R8 write seen
    '{2'd2, 1'b0, 1'b0, 32'd126,       32'h0,        8'd126, 8'd187, 1'b0},
    '{2'd0, 1'b1, 1'b0, 32'h12345678,  32'h0,        8'd130, 8'd183, 1'b0}, // R6 past top
    '{2'd2, 1'b0, 1'b0, 32'd126,       32'h0,        8'd126, 8'd183, 1'b0},
    '{2'd1, 1'b0, 1'b1, 32'h0,         32'h0000,     8'd128, 8'd181, 1'b0}, // R6 write ignored
    '{2'd2, 1'b0, 1'b0, 32'd63,        32'h0,        8'd63,  8'd181, 1'b0},
    '{2'd1, 1'b0, 1'b0, 32'h0,         32'hFF,       8'd64,  8'd180, 1'b0}  // R6 gap reads FF
  };

  task automatic loadAddr(input logic [7:0] v);
    setAddr = 1; setAddrVal = v;
    @(negedge clk);
    setAddr = 0;
  endtask

  task automatic loadCnt(input logic [7:0] v);
    setCnt = 1; setCntVal = v;
    @(negedge clk);
    setCnt = 0;
  endtask

  task automatic access(input logic rd, input logic wide, input logic wm,
                        input logic [31:0] d, output int busyCycles);
    hostRd = rd; hostWr = ~rd; hostWide = wide; wordMode = wm; hostWdata = d;
    @(negedge clk);
    hostRd = 0; hostWr = 0;
    busyCycles = 0;
    while (busy && busyCycles < 10) begin
      busyCycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 curAddr", {24'd0, curAddr}, 32'd0);
    check("R10 remCnt", {24'd0, remCnt}, 32'd0);
    check("R10 done/rdValid", {30'd0, dmaDone, rdValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int expLen;
      v = VECS[i];
      if (v.op == 2'd2) loadAddr(v.data[7:0]);
      else if (v.op == 2'd3) loadCnt(v.data[7:0]);
      else begin
        expLen = v.wide ? 4 : (v.wm ? 2 : 1);
        access(v.op == 2'd1, v.wide, v.wm, v.data, bc);
        check("R9 busy length", bc, expLen);
        check("R9 rdValid", {31'd0, rdValid}, {31'd0, v.op == 2'd1});
        check("R3 dmaDone", {31'd0, dmaDone}, {31'd0, v.expDone});
        if (v.op == 2'd1) check("R7 read data", hostRdata, v.expRd);
      end
      check("R1 R2 address", {24'd0, curAddr}, {24'd0, v.expAddr});
      check("R3 count", {24'd0, remCnt}, {24'd0, v.expCnt});
    end

    // R6: bench memory at the top of the window untouched by the bad write
    check("R6 ram[126]", {24'd0, ram[126]}, 32'd0);
    check("R6 ram[127]", {24'd0, ram[127]}, 32'd0);
    // R7: bench memory lanes of the wide write
    check("R7 ram[82]", {24'd0, ram[82]}, 32'h77);
    check("R7 ram[85]", {24'd0, ram[85]}, 32'h44);

    // R9/R10: strobes and loads during busy are ignored
    loadAddr(8'd80);
    loadCnt(8'd50);
    hostRd = 1; hostWide = 1;
    @(negedge clk);
    hostRd = 0;
    hostWr = 1; setAddr = 1; setAddrVal = 8'd10; setCnt = 1; setCntVal = 8'd3;
    @(negedge clk);
    hostWr = 0; setAddr = 0; setCnt = 0;
    while (busy) @(negedge clk);
    check("R9 strobe during busy", {24'd0, curAddr}, 32'd84);
    check("R10 load during busy", {24'd0, remCnt}, 32'd46);
    check("R9 rdValid", {31'd0, rdValid}, 32'd1);
    check("R7 read data", hostRdata, 32'h66772233);
    @(negedge clk);
    check("R9 no second access", {31'd0, busy}, 32'd0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule